// File: doc/BRIEF.md
# Grouped Timer Interrupt Vector Controller

This block sits beside a 16-bit timer. It turns the timer's five event pulses into one prioritised interrupt request with an 8-bit vector. The events are counter wrap (overflow or underflow), two compare matches and two captures. They fall into three groups: the wrap event alone, the two compares, and the two captures. Each group owns one vector. The vector's low three bits are a fixed group code, where a lower code means a more urgent group. The upper five bits come from a base register that software writes.

Software reaches three byte registers over a plain write strobe and a combinational read path. The registers are a vector base, an enable mask with one bit per source and a master enable, and a flag register. The flag register holds a pending bit per source and two overrun bits, one for the first compare and one for the first capture. Flags are cleared by writing zero to them. Because both compares share one vector, and both captures share another, the handler reads the flag register to tell the sources in a group apart. The request and vector are registered. They follow the flag and mask state one cycle later, so they are a live indication, not a committed transfer. Asserting `irq_ack` while the request is high freezes both request and vector into the next cycle, so the vector can be taken safely. An acknowledge never clears a pending bit.

Top module: `tmr_irq_vectorer`

## Requirements
- R1: After reset, the base, mask and flag registers read 0x00 and `irq_req` is low.
- R2: A one-cycle pulse on `src_evt[i]` sets pending bit i of the flag register (address 2) at the next edge. The source positions are 0 wrap, 1 compare 0, 2 compare 1, 3 capture 0, 4 capture 1. A write to address 2 clears each flag bit whose written bit is 0 and leaves each bit whose written bit is 1 unchanged. Pending bits never clear by themselves.
- R3: An event on compare 0 while its pending bit is already set sets flag bit 5. The same case for capture 0 sets flag bit 6. Repeated events on the other three sources set no overrun bit.
- R4: Mask register (address 1) bit i, for i from 0 to 4, enables source i when set. A pending source with its bit clear never causes a request. Only bits 7 and 4:0 of the mask register are writable.
- R5: When mask bit 7 is clear, `irq_req` goes low one cycle later, whatever the pending and mask bits are, unless an acknowledge is holding the request.
- R6: `irq_vec[7:3]` equals bits 7:3 of the base register (address 0). `irq_vec[2:0]` is 3'b110 for the wrap group, 3'b100 for the compare group and 3'b000 for the capture group.
- R7: When several groups are enabled and pending at once, the group with the lowest code is presented.
- R8: Compare 1 presents the compare group code and capture 1 presents the capture group code, the same codes as compare 0 and capture 0.
- R9: At an edge where `irq_req` and `irq_ack` are both high, the request and vector keep their values for the next cycle even if the flags change. The pending bits are not changed by the acknowledge.
- R10: `irq_req` and `irq_vec` follow the flag and mask state with one cycle of register delay. A pending bit that is set at edge k raises `irq_req` after edge k+1.
- R11: If an event and a flag-clearing write hit the same bit in one cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 base, 1 mask, 2 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| src_evt | input | 5 | One-cycle event pulses, one bit per source |
| irq_req | output | 1 | Interrupt request toward the CPU |
| irq_vec | output | 8 | Vector presented with the request |
| irq_ack | input | 1 | CPU acknowledge; freezes the request and vector for one cycle |

## Verification
Several behaviours are checked by assertions on every cycle. An acknowledged request must keep its vector into the next cycle. A clear master enable must pull the request low. The low vector bits may only carry one of the three legal group codes. An overrun bit may rise only when its pending bit was already set. Pending bits may drop only on a flag write. The bench scenarios cover what needs a chosen history: the exact priority order between groups, which compare or capture source shares which code, and the base bits in the vector. They also cover the one-cycle delay from pending to request, the event winning over a same-cycle clear, and the absence of an overrun on the other sources.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int N_SRC   = 5;
  localparam int N_GRP   = 3;
  localparam int N_OVR   = 2;
  localparam int CODE_W  = 3;

  // source positions
  localparam int SRC_WRAP = 0;
  localparam int SRC_CMP0 = 1;
  localparam int SRC_CMP1 = 2;
  localparam int SRC_CAP0 = 3;
  localparam int SRC_CAP1 = 4;

  // register addresses
  localparam logic [1:0] ADDR_BASE = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  localparam int MASK_GEN_BIT = 7;

  // group index 0 is the most urgent group
  function automatic int src_group(input int s);
    case (s)
      SRC_CAP0, SRC_CAP1: return 0;
      SRC_CMP0, SRC_CMP1: return 1;
      default:            return 2;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] grp_code(input int g);
    case (g)
      0:       return 3'b000;
      1:       return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

  // which source each overrun bit watches
  function automatic int ovr_src(input int o);
    return (o == 0) ? SRC_CMP0 : SRC_CAP0;
  endfunction
endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int NO = N_OVR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] evt,
  input  logic          clr_we,
  input  logic [NS-1:0] keep_pend,
  input  logic [NO-1:0] keep_ovr,
  output logic [NS-1:0] pend,
  output logic [NO-1:0] ovr
);
  logic [NS-1:0] pend_d;
  logic [NO-1:0] ovr_d;
  logic [NO-1:0] ovr_hit;

  always_comb begin
    pend_d = clr_we ? (pend & keep_pend) : pend;
    pend_d = pend_d | evt;
  end

  for (genvar o = 0; o < NO; o++) begin : g_ovr
    assign ovr_hit[o] = evt[ovr_src(o)] & pend[ovr_src(o)];
  end

  always_comb begin
    ovr_d = clr_we ? (ovr & keep_ovr) : ovr;
    ovr_d = ovr_d | ovr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ovr  <= '0;
    end else begin
      pend <= pend_d;
      ovr  <= ovr_d;
    end
  end
endmodule

// File: rtl/tmr_irq_grpsel.sv
module tmr_irq_grpsel
  import tmr_irq_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int NG = N_GRP,
  parameter int CW = CODE_W
) (
  input  logic [NS-1:0] src_act,
  output logic          any_act,
  output logic [CW-1:0] code
);
  logic [NG-1:0] grp_act;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [NS-1:0] member;
    for (genvar s = 0; s < NS; s++) begin : g_src
      assign member[s] = (src_group(s) == g);
    end
    assign grp_act[g] = |(src_act & member);
  end

  always_comb begin
    code = grp_code(NG - 1);
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_act[g]) code = grp_code(g);
    end
  end

  assign any_act = |grp_act;
endmodule

// File: rtl/tmr_irq_vectorer.sv
module tmr_irq_vectorer
  import tmr_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  src_evt,
  output logic              irq_req,
  output logic [DATA_W-1:0] irq_vec,
  input  logic              irq_ack
);
  localparam int BASE_W = DATA_W - CODE_W;
  localparam logic [DATA_W-1:0] MASK_WR =
    (DATA_W'(1) << MASK_GEN_BIT) | DATA_W'((1 << N_SRC) - 1);

  logic [BASE_W-1:0] base_q;
  logic [DATA_W-1:0] mask_q;
  logic [N_SRC-1:0]  pend_q;
  logic [N_OVR-1:0]  ovr_q;
  logic [N_SRC-1:0]  src_act;
  logic              any_act;
  logic [CODE_W-1:0] sel_code;
  logic              flag_we;

  assign flag_we = reg_we && (reg_addr == ADDR_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_BASE) base_q <= reg_wdata[DATA_W-1:CODE_W];
      if (reg_addr == ADDR_MASK) mask_q <= reg_wdata & MASK_WR;
    end
  end

  tmr_irq_flags #(.NS(N_SRC), .NO(N_OVR)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (src_evt),
    .clr_we    (flag_we),
    .keep_pend (reg_wdata[N_SRC-1:0]),
    .keep_ovr  (reg_wdata[N_SRC+N_OVR-1:N_SRC]),
    .pend      (pend_q),
    .ovr       (ovr_q)
  );

  assign src_act = pend_q & mask_q[N_SRC-1:0] & {N_SRC{mask_q[MASK_GEN_BIT]}};

  tmr_irq_grpsel #(.NS(N_SRC), .NG(N_GRP), .CW(CODE_W)) u_sel (
    .src_act (src_act),
    .any_act (any_act),
    .code    (sel_code)
  );

  // presentation register: frozen for the cycle after an accepted ack
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else if (!(irq_req && irq_ack)) begin
      irq_req <= any_act;
      irq_vec <= {base_q, sel_code};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_BASE: reg_rdata = {base_q, {CODE_W{1'b0}}};
      ADDR_MASK: reg_rdata = mask_q;
      ADDR_FLAG: reg_rdata[N_SRC+N_OVR-1:0] = {ovr_q, pend_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_irq_checker.sv
module tmr_irq_checker
  import tmr_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             irq_req,
  input logic             irq_ack,
  input logic [7:0]       irq_vec,
  input logic [N_SRC-1:0] pend,
  input logic [N_OVR-1:0] ovr,
  input logic             gen
);
  AST_ACK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (irq_req && $stable(irq_vec))); // R9

  AST_GEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !(irq_req && irq_ack)) |=> !irq_req); // R5

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b000 || irq_vec[2:0] == 3'b100 || irq_vec[2:0] == 3'b110)); // R6

  AST_OVR_CMP_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr[0]) |-> $past(pend[SRC_CMP0])); // R3

  AST_OVR_CAP_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr[1]) |-> $past(pend[SRC_CAP0])); // R3

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == ADDR_FLAG) |=> ((pend & $past(pend)) == $past(pend))); // R2
endmodule

bind tmr_irq_vectorer tmr_irq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .irq_req  (irq_req),
  .irq_ack  (irq_ack),
  .irq_vec  (irq_vec),
  .pend     (pend_q),
  .ovr      (ovr_q),
  .gen      (mask_q[7])
);

// File: tb/test_tmr_irq_vectorer.sv
module test_tmr_irq_vectorer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [4:0] src_evt = 5'd0;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       irq_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_vectorer i_tmr_irq_vectorer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] e);
    src_evt = e;
    tick(1);
    src_evt = 5'd0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1 base", d, 8'h00);
    rd(2'd1, d); check("R1 mask", d, 8'h00);
    rd(2'd2, d); check("R1 flags", d, 8'h00);
    check("R1 req", {7'd0, irq_req}, 8'h00);
  endtask

  task automatic t_pend_clear;
    logic [7:0] d;
    pulse(5'b00001);
    rd(2'd2, d); check("R2 wrap pending", d, 8'h01);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R2 write one keeps", d, 8'h01);
    tick(1);
    check("R4 masked no req", {7'd0, irq_req}, 8'h00);
    wr(2'd2, 8'hFE);
    rd(2'd2, d); check("R2 write zero clears", d, 8'h00);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    pulse(5'b00010); pulse(5'b00010);
    rd(2'd2, d); check("R3 cmp0 overrun", d, 8'h22);
    pulse(5'b00100); pulse(5'b00100);
    pulse(5'b10000); pulse(5'b10000);
    rd(2'd2, d); check("R3 no overrun on other sources", d, 8'h36);
    pulse(5'b01000); pulse(5'b01000);
    rd(2'd2, d); check("R3 cap0 overrun", d, 8'h7E);
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R2 clear all", d, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(2'd0, 8'hAF);
    rd(2'd0, d); check("R6 base readback", d, 8'hA8);
    wr(2'd1, 8'hE0);
    rd(2'd1, d); check("R4 writable mask bits", d, 8'h80);
    pulse(5'b00001);
    tick(2);
    check("R4 source mask off", {7'd0, irq_req}, 8'h00);
    wr(2'd1, 8'h81);
    check("R10 not yet", {7'd0, irq_req}, 8'h00);
    tick(1);
    check("R10 req after one cycle", {7'd0, irq_req}, 8'h01);
    check("R6 wrap vector", irq_vec, 8'hAE);
    wr(2'd1, 8'h01);
    tick(1);
    check("R5 global off", {7'd0, irq_req}, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_prio;
    wr(2'd1, 8'h9F);
    pulse(5'b10101);
    tick(1);
    check("R7 capture first", irq_vec, 8'hA8);
    check("R8 capture1 req", {7'd0, irq_req}, 8'h01);
    wr(2'd2, 8'hEF);
    tick(1);
    check("R8 compare1 code", irq_vec, 8'hAC);
    wr(2'd2, 8'hEB);
    tick(1);
    check("R7 wrap last", irq_vec, 8'hAE);
    wr(2'd2, 8'h00);
    tick(1);
    check("R2 req drops after clear", {7'd0, irq_req}, 8'h00);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    pulse(5'b01000);
    tick(1);
    check("R10 cap0 presented", irq_vec, 8'hA8);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    rd(2'd2, d); check("R9 ack keeps pending", d, 8'h08);
    irq_ack = 1'b1;
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00;
    tick(1);
    irq_ack = 1'b0; reg_we = 1'b0;
    check("R9 req held", {7'd0, irq_req}, 8'h01);
    check("R9 vec held", irq_vec, 8'hA8);
    tick(1);
    check("R9 released", {7'd0, irq_req}, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] d;
    pulse(5'b01000);
    src_evt = 5'b01000;
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00;
    tick(1);
    src_evt = 5'd0; reg_we = 1'b0;
    rd(2'd2, d); check("R11 event beats clear", d, 8'h48);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    tick(2);
    t_reset;
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_pend_clear;
    t_overrun;
    t_mask;
    t_prio;
    t_ack;
    t_race;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule